// File: doc/BRIEF.md
# Low-Power Domain Write Synchronizer

This block carries 32-bit register writes from a fast bus clock into a slow, always-on domain clocked at a few tens of kilohertz. A write arrives at the bus side, is parked in a staging register, and is announced to the slow side by flipping a request toggle. The slow side resynchronizes that toggle, commits the staged value into its register array, and returns an acknowledge toggle, which the bus side resynchronizes in turn to end the transfer. Only one transfer may be in flight. A second synchronized write during that window is discarded and flagged as an error.

Software follows progress through a status word that carries busy, ready-for-next, done and error flags. Any of the last three can be routed to a single interrupt line through an interrupt-enable word. That enable word lives in the bus domain and takes effect immediately, without a transfer. The done flag is cleared by reading the status word. The error flag is cleared by writing a one to its bit in the status word, and that write travels through the synchronizer like any other.

Top module: `lp_write_sync`

## Requirements
- R1: After reset the status word reads 0x200 (only ready-for-next set), the interrupt-enable word reads 0, every slow register reads 0 and the interrupt output is low.
- R2: A write to slow register index k (addresses 0 to NUM_REGS-1) changes that register on the fourth rising slow-clock edge after the bus edge that accepts it, and not on any earlier edge. The written value then reads back unchanged.
- R3: Status bit 10 (busy) is set from the bus cycle after an accepted write until the transfer completes. Status bit 9 (ready-for-next) is its complement.
- R4: When the acknowledge returns, busy clears and status bit 8 (done) is set.
- R5: A read of the status word (address NUM_REGS) clears done. Reads of any other address leave it unchanged.
- R6: A synchronized write accepted while busy is dropped. The in-flight data still commits, and status bit 7 (error) is set.
- R7: A write of 1 to status bit 7 clears the error only when that transfer completes, and the write also sets done. A status write with bit 7 at 0 leaves the error set.
- R8: A write to the interrupt-enable word (address NUM_REGS+1, bits 9, 8 and 7) reads back on the next cycle, even while busy. It sets neither busy, done nor error.
- R9: The interrupt output is high exactly when some status bit among 9, 8 and 7 is set together with the enable bit at the same position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| busClk | input | 1 | Bus-domain clock |
| busRstN | input | 1 | Bus-domain asynchronous reset, active low |
| slowClk | input | 1 | Low-power-domain clock |
| slowRstN | input | 1 | Low-power-domain asynchronous reset, active low |
| wrEn | input | 1 | Write strobe, one bus cycle per write |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data |
| rdEn | input | 1 | Read strobe; a read of the status word clears done |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | DATA_W | Read data, combinational from rdAddr |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: eight slow registers, a three-stage request synchronizer (four slow edges per commit) and a two-stage acknowledge synchronizer. It runs a 40 ns slow clock against the 4 ns bus clock. This ten-to-one ratio is still wide enough that a second write lands well inside the busy window, which makes collisions easy to provoke. It also keeps each transfer down to a few dozen bus cycles. The slow clock is offset from the bus clock, so the bench can count slow edges after a write and test that the commit lands on the fourth edge and not on the third.

// File: rtl/lpws_pkg.sv
package lpws_pkg;
  // Status and interrupt-enable bit positions shared by both words.
  localparam int BIT_WERR  = 7;
  localparam int BIT_WDONE = 8;
  localparam int BIT_WNEXT = 9;
  localparam int BIT_BUSY  = 10;

  // Control to datapath strobes.
  typedef struct packed {
    logic stageLoad;  // capture address and data into staging
    logic reqTog;     // request toggle crossing into the slow domain
  } lpwsStrobes_t;
endpackage

// File: rtl/lpws_ctrl.sv
module lpws_ctrl
  import lpws_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int NUM_REGS  = 8,
  parameter int ACK_DEPTH = 2
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              ackTog,
  input  logic              stagedClrErr,
  output lpwsStrobes_t      strobes,
  output logic [DATA_W-1:0] statusWord,
  output logic [DATA_W-1:0] ienWord,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(NUM_REGS);
  localparam logic [ADDR_W-1:0] IEN_ADDR    = ADDR_W'(NUM_REGS + 1);
  localparam logic [DATA_W-1:0] IEN_MASK    =
    (DATA_W'(1) << BIT_WNEXT) | (DATA_W'(1) << BIT_WDONE) | (DATA_W'(1) << BIT_WERR);

  logic                 busy, reqTog, wDone, wErr;
  logic [ACK_DEPTH-1:0] ackSync;
  logic [DATA_W-1:0]    ienReg;
  logic                 isIenWr, syncWr, accept, collide, finish, readStatus;

  assign isIenWr    = wrEn && (wrAddr == IEN_ADDR);
  assign syncWr     = wrEn && !isIenWr;
  assign accept     = syncWr && !busy;
  assign collide    = syncWr && busy;
  assign finish     = busy && (ackSync[ACK_DEPTH-1] == reqTog);
  assign readStatus = rdEn && (rdAddr == STATUS_ADDR);

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) ackSync <= '0;
    else          ackSync <= {ackSync[ACK_DEPTH-2:0], ackTog};
  end

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      busy   <= 1'b0;
      reqTog <= 1'b0;
      wDone  <= 1'b0;
      wErr   <= 1'b0;
      ienReg <= '0;
    end else begin
      if (accept)      busy <= 1'b1;
      else if (finish) busy <= 1'b0;
      if (accept) reqTog <= ~reqTog;
      // A completion in the same cycle as a status read is kept.
      if (finish)          wDone <= 1'b1;
      else if (readStatus) wDone <= 1'b0;
      // A new collision outranks a clear that completes in the same cycle.
      if (collide)                     wErr <= 1'b1;
      else if (finish && stagedClrErr) wErr <= 1'b0;
      if (isIenWr) ienReg <= wrData & IEN_MASK;
    end
  end

  always_comb begin
    statusWord            = '0;
    statusWord[BIT_BUSY]  = busy;
    statusWord[BIT_WNEXT] = !busy;
    statusWord[BIT_WDONE] = wDone;
    statusWord[BIT_WERR]  = wErr;
  end

  assign ienWord           = ienReg;
  assign irq               = |(statusWord & ienReg);
  assign strobes.stageLoad = accept;
  assign strobes.reqTog    = reqTog;

  // R3: an accepted synchronized write makes the block busy.
  p_accept_busy_r3: assert property (@(posedge busClk) disable iff (!busRstN)
    (wrEn && wrAddr != IEN_ADDR && !busy) |=> busy);
  // R4: busy holds until the acknowledge toggle has come back.
  p_busy_until_ack_r4: assert property (@(posedge busClk) disable iff (!busRstN)
    (busy && ackSync[ACK_DEPTH-1] != reqTog) |=> busy);
  // R6: a synchronized write while busy raises the error.
  p_collide_err_r6: assert property (@(posedge busClk) disable iff (!busRstN)
    (wrEn && wrAddr != IEN_ADDR && busy) |=> wErr);
  // R5: a status read without a completion clears done.
  p_read_clears_r5: assert property (@(posedge busClk) disable iff (!busRstN)
    (rdEn && rdAddr == STATUS_ADDR && !finish) |=> !wDone);
  // R7: the error stays set until a transfer completes.
  p_err_sticky_r7: assert property (@(posedge busClk) disable iff (!busRstN)
    (wErr && !finish) |=> wErr);
  // R8: the enable word changes only on its own write.
  p_ien_hold_r8: assert property (@(posedge busClk) disable iff (!busRstN)
    !(wrEn && wrAddr == IEN_ADDR) |=> $stable(ienReg));
endmodule

// File: rtl/lpws_datapath.sv
module lpws_datapath
  import lpws_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int NUM_REGS   = 8,
  parameter int SYNC_DEPTH = 3
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic              slowClk,
  input  logic              slowRstN,
  input  lpwsStrobes_t      strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] statusWord,
  input  logic [DATA_W-1:0] ienWord,
  output logic              ackTog,
  output logic              stagedClrErr,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(NUM_REGS);
  localparam logic [ADDR_W-1:0] IEN_ADDR    = ADDR_W'(NUM_REGS + 1);

  logic [ADDR_W-1:0]     stAddr;
  logic [DATA_W-1:0]     stData;
  logic [SYNC_DEPTH-1:0] reqSync;
  logic                  ackReg, commit;
  logic [DATA_W-1:0]     slowRegs [NUM_REGS];

  // Bus-domain staging, held steady for the whole transfer.
  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      stAddr <= '0;
      stData <= '0;
    end else if (strobes.stageLoad) begin
      stAddr <= wrAddr;
      stData <= wrData;
    end
  end

  assign stagedClrErr = (stAddr == STATUS_ADDR) && stData[BIT_WERR];

  // Slow-domain request synchronizer and acknowledge toggle.
  always_ff @(posedge slowClk or negedge slowRstN) begin
    if (!slowRstN) begin
      reqSync <= '0;
      ackReg  <= 1'b0;
    end else begin
      reqSync <= {reqSync[SYNC_DEPTH-2:0], strobes.reqTog};
      if (commit) ackReg <= reqSync[SYNC_DEPTH-1];
    end
  end

  assign commit = reqSync[SYNC_DEPTH-1] != ackReg;
  assign ackTog = ackReg;

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slowReg
      always_ff @(posedge slowClk or negedge slowRstN) begin
        if (!slowRstN)                                 slowRegs[g] <= '0;
        else if (commit && stAddr == ADDR_W'(g)) slowRegs[g] <= stData;
      end
    end
  endgenerate

  always_comb begin
    rdData = '0;
    if (rdAddr == STATUS_ADDR)   rdData = statusWord;
    else if (rdAddr == IEN_ADDR) rdData = ienWord;
    else begin
      for (int i = 0; i < NUM_REGS; i++)
        if (rdAddr == ADDR_W'(i)) rdData = slowRegs[i];
    end
  end

  // R2: each request is committed exactly once, in a single slow cycle.
  p_single_commit_r2: assert property (@(posedge slowClk) disable iff (!slowRstN)
    commit |=> !commit);
endmodule

// File: rtl/lp_write_sync.sv
module lp_write_sync
  import lpws_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int NUM_REGS   = 8,
  parameter int SYNC_DEPTH = 3,
  parameter int ACK_DEPTH  = 2
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic              slowClk,
  input  logic              slowRstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  lpwsStrobes_t      strobes;
  logic [DATA_W-1:0] statusWord, ienWord;
  logic              ackTog, stagedClrErr;

  lpws_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ACK_DEPTH(ACK_DEPTH)
  ) i_ctrl (
    .busClk(busClk), .busRstN(busRstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdEn(rdEn), .rdAddr(rdAddr), .ackTog(ackTog),
    .stagedClrErr(stagedClrErr), .strobes(strobes), .statusWord(statusWord),
    .ienWord(ienWord), .irq(irq)
  );

  lpws_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SYNC_DEPTH(SYNC_DEPTH)
  ) i_datapath (
    .busClk(busClk), .busRstN(busRstN), .slowClk(slowClk), .slowRstN(slowRstN),
    .strobes(strobes), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .statusWord(statusWord), .ienWord(ienWord), .ackTog(ackTog),
    .stagedClrErr(stagedClrErr), .rdData(rdData)
  );
endmodule

// File: tb/test_lp_write_sync.sv
module test_lp_write_sync;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd8;
  localparam logic [ADDR_W-1:0] A_IEN  = 4'd9;

  logic              busClk, slowClk, busRstN, slowRstN;
  logic              wrEn, rdEn, irq;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [DATA_W-1:0] wrData, rdData;

  lp_write_sync i_lp_write_sync (
    .busClk(busClk), .busRstN(busRstN), .slowClk(slowClk), .slowRstN(slowRstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdEn(rdEn),
    .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  initial busClk = 1'b0;
  always #2 busClk = ~busClk;           // 250 MHz
  initial begin
    slowClk = 1'b0;
    #1;
    forever #20 slowClk = ~slowClk;     // offset slow clock
  end

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] exp;
    string             tag;
  } item_t;

  item_t expQ[$];
  item_t cur;
  int    nCmp = 0;
  int    nBad = 0;

  task automatic chk(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp,
                     input string tag);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compares each read against the scoreboard queue.
  always @(negedge busClk) begin
    if (rdEn) begin
      if (expQ.size() == 0) chk(rdData, 32'hxxxxxxxx, "scoreboard empty");
      else begin
        cur = expQ.pop_front();
        chk(rdData, cur.exp, cur.tag);
      end
    end
  end

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(posedge busClk); #1;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge busClk); #1;
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e,
                         input string tag);
    item_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    expQ.push_back(it);
    @(posedge busClk); #1;
    rdEn = 1'b1; rdAddr = a;
    @(posedge busClk); #1;
    rdEn = 1'b0;
  endtask

  task automatic waitBus(input int n);
    repeat (n) @(posedge busClk);
    #1;
  endtask

  task automatic writeWait(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    busWrite(a, d);
    waitBus(70);
  endtask

  initial begin
    repeat (100000) @(posedge busClk);
    nCmp++; nBad++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    wrEn = 0; rdEn = 0; wrAddr = '0; rdAddr = '0; wrData = '0;
    busRstN = 0; slowRstN = 0;
    #50;
    busRstN = 1; slowRstN = 1;
    waitBus(3);

    // R1: reset state
    chk({31'd0, irq}, 32'd0, "R1 irq after reset");
    busRead(A_STAT, 32'h200, "R1 status after reset");
    busRead(A_IEN, 32'h0, "R1 ien after reset");
    busRead(4'd5, 32'h0, "R1 slow reg after reset");

    // R2/R3: commit lands on the fourth slow edge; busy meanwhile
    @(negedge slowClk);
    busWrite(4'd3, 32'hA5A50003);
    busRead(A_STAT, 32'h400, "R3 busy during transfer");
    rdAddr = 4'd3;
    repeat (3) @(posedge slowClk);
    #1;
    chk(rdData, 32'h0, "R2 not committed after third slow edge");
    @(posedge slowClk);
    #1;
    chk(rdData, 32'hA5A50003, "R2 committed on fourth slow edge");
    waitBus(10);
    busRead(A_STAT, 32'h300, "R4 done after completion");
    busRead(A_STAT, 32'h200, "R5 status read cleared done");
    busRead(4'd3, 32'hA5A50003, "R2 readback reg3");

    // R5: other reads leave done alone
    writeWait(4'd1, 32'h00000011);
    busRead(4'd1, 32'h00000011, "R2 readback reg1");
    busRead(A_STAT, 32'h300, "R5 done kept by non-status read");
    busRead(A_STAT, 32'h200, "R5 done cleared");

    // R6: collision
    busWrite(4'd2, 32'h00000022);
    busWrite(4'd2, 32'h00000099);
    waitBus(70);
    busRead(A_STAT, 32'h380, "R6 error set on collision");
    busRead(4'd2, 32'h00000022, "R6 second write dropped");

    // R9/R8: interrupt masking, enable word at bus speed
    busWrite(A_IEN, 32'h80);
    chk({31'd0, irq}, 32'd1, "R9 irq from error");
    busRead(A_IEN, 32'h80, "R8 ien readback");
    busWrite(A_IEN, 32'h0);
    chk({31'd0, irq}, 32'd0, "R9 irq masked");
    busWrite(A_IEN, 32'h200);
    chk({31'd0, irq}, 32'd1, "R9 irq from ready-for-next");
    busWrite(A_IEN, 32'h0);
    busRead(A_STAT, 32'h280, "R8 ien writes set no busy or done");

    // R7: clearing the error through the synchronizer
    writeWait(A_STAT, 32'h0);
    busRead(A_STAT, 32'h380, "R7 zero bit keeps error");
    busWrite(A_STAT, 32'h80);
    busRead(A_STAT, 32'h480, "R7 error held while busy");
    waitBus(70);
    busRead(A_STAT, 32'h300, "R7 error cleared on completion");
    busRead(A_STAT, 32'h200, "R5 done cleared again");

    // R8: enable write during a transfer is no collision
    busWrite(4'd4, 32'h00000044);
    busWrite(A_IEN, 32'h100);
    busRead(A_IEN, 32'h100, "R8 ien written while busy");
    busRead(A_STAT, 32'h400, "R8 no error from ien write");
    chk({31'd0, irq}, 32'd0, "R9 no irq while busy");
    waitBus(70);
    chk({31'd0, irq}, 32'd1, "R9 irq on done");
    busRead(A_STAT, 32'h300, "R4 done for reg4 write");
    chk({31'd0, irq}, 32'd0, "R9 irq drops after status read");
    busRead(4'd4, 32'h00000044, "R2 readback reg4");
    busWrite(A_IEN, 32'h0);

    // R2: edge indices and data patterns
    writeWait(4'd0, 32'hDEADBEEF);
    writeWait(4'd7, 32'h77770007);
    busRead(4'd0, 32'hDEADBEEF, "R2 readback reg0");
    busRead(4'd7, 32'h77770007, "R2 readback reg7");
    busRead(4'd3, 32'hA5A50003, "R2 reg3 untouched");
    busRead(A_STAT, 32'h300, "R4 done after back-to-back writes");

    waitBus(4);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule